// File: doc/BRIEF.md
# Timer DMA Request Generator

This block drives the level DMA request lines of a PWM timer/counter. It has one overflow request and one request per compare/capture channel. It watches the counter's update events (overflow, underflow, re-trigger), the per-channel compare-match and capture-valid strobes, and the ramp and count-direction start pulses. From these it decides when each request is raised. The DMA engine lowers a request by acknowledging it. A capture channel's request is lowered instead when its capture register is read.

The trigger source for each request depends on the operating mode:

- **Plain mode:** update events raise the overflow request and compare matches raise the channel requests.
- **One-shot mode:** update events are held in a pending state. Only a software command turns a pending event into an overflow request. Compare channels are silenced.
- **Circular-buffer mode:** a waveform mode with two phases per period (two-ramp, two-ramp alternate, or dual-slope both-edge) combined with circular buffering. Circular channels request at the start of the second phase. The overflow request is raised at the start of the first phase, but only if the overflow request was acknowledged during the preceding second phase.

All outputs are registered. A request becomes visible in the cycle after the event that sets it.

Top module: `pwm_dma_reqgen`

## Requirements
- R1: While the active-low synchronous reset is asserted, and in the first cycle after it, the overflow request and all channel requests are low.
- R2: With one-shot mode off and no circular alignment, an overflow, underflow or re-trigger event in cycle t raises the overflow request in cycle t+1.
- R3: With one-shot mode on, an update event does not raise the overflow request. A one-shot command in cycle t raises the request in cycle t+1 only if an update event was recorded before or in cycle t. The command consumes the recorded event.
- R4: Switching one-shot mode off discards a recorded update event, so a later command in one-shot mode raises nothing.
- R5: The overflow acknowledge lowers the overflow request in the next cycle. If a set event and the acknowledge occur in the same cycle, the request stays high.
- R6: A compare channel (capture-mode bit 0) sets its request on a compare match while one-shot mode is off. Its acknowledge clears the request. A match and an acknowledge in the same cycle leave the request high.
- R7: While one-shot mode is on, compare matches set no channel request.
- R8: A capture channel (capture-mode bit 1) sets its request on capture-valid and clears it on a capture-register read. The one-shot bit and the channel acknowledge have no effect on it.
- R9: In two-ramp (mode code 2) and two-ramp alternate (mode code 1), a compare channel with circular buffering enabled ignores matches and requests on the ramp B start pulse. Non-circular channels stay match-based.
- R10: In the two-ramp modes with any circular buffer enabled, update events do not raise the overflow request. The ramp A start pulse raises it only if an overflow acknowledge occurred since the last ramp B start.
- R11: In dual-slope both-edge mode (mode code 5), the circular channel requests on the down-count start pulse. The overflow request is raised on the up-count start pulse only if an overflow acknowledge occurred since the last down-count start. The ramp start pulses have no effect in this mode.
- R12: In the other waveform modes (codes 0, 3, 4), circular-buffer enables are ignored. Channels use matches and the overflow request uses update events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_mode_i | input | 3 | Waveform mode code (0 single-slope, 1 two-ramp alternate, 2 two-ramp, 3 dual-slope top, 4 dual-slope bottom, 5 dual-slope both) |
| oneshot_en_i | input | 1 | One-shot request mode |
| oneshot_cmd_i | input | 1 | One-shot command strobe |
| ovf_evt_i | input | 1 | Counter overflow event |
| unf_evt_i | input | 1 | Counter underflow event |
| retrig_evt_i | input | 1 | Re-trigger event |
| ramp_a_start_i | input | 1 | Start of ramp A |
| ramp_b_start_i | input | 1 | Start of ramp B |
| up_start_i | input | 1 | Start of up-counting phase |
| down_start_i | input | 1 | Start of down-counting phase |
| match_i | input | N_CH | Per-channel compare-match strobes |
| capture_valid_i | input | N_CH | Per-channel captured-data-valid strobes |
| cap_mode_i | input | N_CH | Per-channel capture mode (1) or compare mode (0) |
| circ_en_i | input | N_CH | Per-channel circular-buffer enable |
| cap_read_i | input | N_CH | Per-channel capture-register read strobes |
| ovf_ack_i | input | 1 | DMA acknowledge for the overflow request |
| ch_ack_i | input | N_CH | DMA acknowledges for the channel requests |
| ovf_req_o | output | 1 | Overflow DMA request level |
| ch_req_o | output | N_CH | Channel DMA request levels |

## Verification
The bench checks that a one-shot command with nothing recorded raises nothing. It also checks that a recorded event dies when one-shot mode is toggled off and on. A design that latched events unconditionally would fire a stray request in either case.

Same-cycle set and clear collisions are driven on both the overflow and a compare channel. A design that let the clear win would drop a request the DMA has not yet served.

In the two-phase modes the bench checks three cases:

- An acknowledge given before the clearing phase start does not qualify the next overflow request. A design that tracked acknowledges without phase reset would request early.
- Circular channels ignore matches while neighbouring channels still honour them.
- The ramp pulses are inert in dual-slope mode, which catches a design that decodes the phase pulses regardless of mode.

// File: rtl/pwm_dma_pkg.sv
package pwm_dma_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        WM_SINGLE      = 3'd0,
        WM_TWORAMP_ALT = 3'd1,
        WM_TWORAMP     = 3'd2,
        WM_DUAL_TOP    = 3'd3,
        WM_DUAL_BOT    = 3'd4,
        WM_DUAL_BOTH   = 3'd5
    } wave_mode_e;

    // Overflow controller: request level x recorded one-shot event
    typedef enum logic [1:0] {
        OVF_IDLE      = 2'd0,
        OVF_ARMED     = 2'd1,
        OVF_REQ       = 2'd2,
        OVF_REQ_ARMED = 2'd3
    } ovf_state_e;

    // Acknowledge bookkeeping for the second phase of a two-phase period
    typedef enum logic {
        PH_NO_ACK = 1'b0,
        PH_ACKED  = 1'b1
    } phase_ack_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_REQ  = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        SRC_MATCH   = 2'd0,
        SRC_CIRC    = 2'd1,
        SRC_CAPTURE = 2'd2
    } ch_src_e;

endpackage

// File: rtl/pwm_dma_phase_dec.sv
module pwm_dma_phase_dec
    import pwm_dma_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic              ramp_a_start_i,
    input  logic              ramp_b_start_i,
    input  logic              up_start_i,
    input  logic              down_start_i,
    output logic              align_mode_o,
    output logic              first_start_o,
    output logic              second_start_o
);

    always_comb begin
        unique case (wave_mode_e'(mode_i))
            WM_TWORAMP, WM_TWORAMP_ALT: begin
                align_mode_o   = 1'b1;
                first_start_o  = ramp_a_start_i;
                second_start_o = ramp_b_start_i;
            end
            WM_DUAL_BOTH: begin
                align_mode_o   = 1'b1;
                first_start_o  = up_start_i;
                second_start_o = down_start_i;
            end
            default: begin
                align_mode_o   = 1'b0;
                first_start_o  = 1'b0;
                second_start_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pwm_dma_ovf_ctrl.sv
module pwm_dma_ovf_ctrl
    import pwm_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic align_en_i,
    input  logic first_start_i,
    input  logic second_start_i,
    input  logic update_i,
    input  logic oneshot_en_i,
    input  logic oneshot_cmd_i,
    input  logic ack_i,
    output logic req_o
);

    ovf_state_e state_q, state_d;
    phase_ack_e ackph_q, ackph_d;

    logic req_cur, pend_cur;
    logic set_evt, track_pend, req_nxt, pend_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OVF_IDLE;
            ackph_q <= PH_NO_ACK;
        end else begin
            state_q <= state_d;
            ackph_q <= ackph_d;
        end
    end

    // Next-state logic
    always_comb begin
        req_cur  = (state_q == OVF_REQ) || (state_q == OVF_REQ_ARMED);
        pend_cur = (state_q == OVF_ARMED) || (state_q == OVF_REQ_ARMED);

        if (align_en_i) begin
            set_evt = first_start_i && (ackph_q == PH_ACKED);
        end else if (!oneshot_en_i) begin
            set_evt = update_i;
        end else begin
            set_evt = oneshot_cmd_i && (pend_cur || update_i);
        end

        track_pend = oneshot_en_i && !align_en_i;
        pend_nxt   = track_pend && !oneshot_cmd_i && (pend_cur || update_i);
        req_nxt    = set_evt || (req_cur && !ack_i);

        unique case ({req_nxt, pend_nxt})
            2'b00: state_d = OVF_IDLE;
            2'b01: state_d = OVF_ARMED;
            2'b10: state_d = OVF_REQ;
            2'b11: state_d = OVF_REQ_ARMED;
            default: state_d = OVF_IDLE;
        endcase

        unique case (ackph_q)
            PH_NO_ACK: ackph_d = ack_i ? PH_ACKED : PH_NO_ACK;
            PH_ACKED:  ackph_d = (second_start_i && !ack_i) ? PH_NO_ACK : PH_ACKED;
            default:   ackph_d = PH_NO_ACK;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            OVF_REQ, OVF_REQ_ARMED: req_o = 1'b1;
            OVF_IDLE, OVF_ARMED:    req_o = 1'b0;
            default:                req_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_dma_ch_ctrl.sv
module pwm_dma_ch_ctrl
    import pwm_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_mode_i,
    input  logic circ_align_i,
    input  logic second_start_i,
    input  logic match_i,
    input  logic cap_valid_i,
    input  logic oneshot_en_i,
    input  logic ack_i,
    input  logic cap_read_i,
    output logic req_o
);

    ch_state_e state_q, state_d;
    ch_src_e   src;
    logic      set_evt, clr_evt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        if (cap_mode_i)        src = SRC_CAPTURE;
        else if (circ_align_i) src = SRC_CIRC;
        else                   src = SRC_MATCH;

        unique case (src)
            SRC_CAPTURE: begin
                set_evt = cap_valid_i;
                clr_evt = cap_read_i;
            end
            SRC_CIRC: begin
                set_evt = second_start_i && !oneshot_en_i;
                clr_evt = ack_i;
            end
            SRC_MATCH: begin
                set_evt = match_i && !oneshot_en_i;
                clr_evt = ack_i;
            end
            default: begin
                set_evt = 1'b0;
                clr_evt = 1'b0;
            end
        endcase

        unique case (state_q)
            CH_IDLE: state_d = set_evt ? CH_REQ : CH_IDLE;
            CH_REQ:  state_d = (clr_evt && !set_evt) ? CH_IDLE : CH_REQ;
            default: state_d = CH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            CH_REQ:  req_o = 1'b1;
            CH_IDLE: req_o = 1'b0;
            default: req_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_dma_reqgen.sv
module pwm_dma_reqgen
    import pwm_dma_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] wave_mode_i,
    input  logic              oneshot_en_i,
    input  logic              oneshot_cmd_i,
    input  logic              ovf_evt_i,
    input  logic              unf_evt_i,
    input  logic              retrig_evt_i,
    input  logic              ramp_a_start_i,
    input  logic              ramp_b_start_i,
    input  logic              up_start_i,
    input  logic              down_start_i,
    input  logic [N_CH-1:0]   match_i,
    input  logic [N_CH-1:0]   capture_valid_i,
    input  logic [N_CH-1:0]   cap_mode_i,
    input  logic [N_CH-1:0]   circ_en_i,
    input  logic [N_CH-1:0]   cap_read_i,
    input  logic              ovf_ack_i,
    input  logic [N_CH-1:0]   ch_ack_i,
    output logic              ovf_req_o,
    output logic [N_CH-1:0]   ch_req_o
);

    logic align_mode, first_start, second_start;
    logic any_circ, update_evt;

    assign any_circ   = |circ_en_i;
    assign update_evt = ovf_evt_i | unf_evt_i | retrig_evt_i;

    pwm_dma_phase_dec u_phase (
        .mode_i         (wave_mode_i),
        .ramp_a_start_i (ramp_a_start_i),
        .ramp_b_start_i (ramp_b_start_i),
        .up_start_i     (up_start_i),
        .down_start_i   (down_start_i),
        .align_mode_o   (align_mode),
        .first_start_o  (first_start),
        .second_start_o (second_start)
    );

    pwm_dma_ovf_ctrl u_ovf (
        .clk            (clk),
        .rst_n          (rst_n),
        .align_en_i     (align_mode && any_circ),
        .first_start_i  (first_start),
        .second_start_i (second_start),
        .update_i       (update_evt),
        .oneshot_en_i   (oneshot_en_i),
        .oneshot_cmd_i  (oneshot_cmd_i),
        .ack_i          (ovf_ack_i),
        .req_o          (ovf_req_o)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm_dma_ch_ctrl u_ch (
            .clk            (clk),
            .rst_n          (rst_n),
            .cap_mode_i     (cap_mode_i[g]),
            .circ_align_i   (circ_en_i[g] && align_mode),
            .second_start_i (second_start),
            .match_i        (match_i[g]),
            .cap_valid_i    (capture_valid_i[g]),
            .oneshot_en_i   (oneshot_en_i),
            .ack_i          (ch_ack_i[g]),
            .cap_read_i     (cap_read_i[g]),
            .req_o          (ch_req_o[g])
        );
    end

endmodule

// File: rtl/pwm_dma_reqgen_chk.sv
module pwm_dma_reqgen_chk
    import pwm_dma_pkg::*;
#(
    parameter int N_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] wave_mode_i,
    input logic              oneshot_en_i,
    input logic              oneshot_cmd_i,
    input logic              ovf_evt_i,
    input logic              unf_evt_i,
    input logic              retrig_evt_i,
    input logic              ramp_a_start_i,
    input logic              ramp_b_start_i,
    input logic              up_start_i,
    input logic [N_CH-1:0]   capture_valid_i,
    input logic [N_CH-1:0]   cap_mode_i,
    input logic [N_CH-1:0]   circ_en_i,
    input logic [N_CH-1:0]   cap_read_i,
    input logic              ovf_ack_i,
    input logic              ovf_req_o,
    input logic [N_CH-1:0]   ch_req_o
);

    logic any_ovf_cause;
    assign any_ovf_cause = ovf_evt_i | unf_evt_i | retrig_evt_i | oneshot_cmd_i
                         | ramp_a_start_i | up_start_i;

    // R1: reset leaves every request low
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!ovf_req_o && (ch_req_o == '0)));

    // R2, R3, R10: overflow request only rises after a qualifying cause
    p_ovf_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_req_o) |-> $past(any_ovf_cause));

    // R3: in one-shot mode nothing but a command (or phase A start) raises it
    p_oneshot_no_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_en_i && !oneshot_cmd_i && !ramp_a_start_i && !up_start_i && !ovf_req_o)
        |=> !ovf_req_o);

    // R5: acknowledge without a set event lowers the overflow request
    p_ovf_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_req_o && ovf_ack_i && !any_ovf_cause) |=> !ovf_req_o);

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        // R7: compare channels stay silent in one-shot mode
        p_match_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (oneshot_en_i && !cap_mode_i[g] && !ch_req_o[g]) |=> !ch_req_o[g]);

        // R8: capture read without new data clears the request
        p_cap_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_mode_i[g] && cap_read_i[g] && !capture_valid_i[g]) |=> !ch_req_o[g]);

        // R9: circular channels in two-ramp modes wait for ramp B start
        p_circ_no_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((wave_mode_i == WM_TWORAMP || wave_mode_i == WM_TWORAMP_ALT)
             && circ_en_i[g] && !cap_mode_i[g] && !ramp_b_start_i && !ch_req_o[g])
            |=> !ch_req_o[g]);
    end

endmodule

bind pwm_dma_reqgen pwm_dma_reqgen_chk #(.N_CH(N_CH)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .wave_mode_i     (wave_mode_i),
    .oneshot_en_i    (oneshot_en_i),
    .oneshot_cmd_i   (oneshot_cmd_i),
    .ovf_evt_i       (ovf_evt_i),
    .unf_evt_i       (unf_evt_i),
    .retrig_evt_i    (retrig_evt_i),
    .ramp_a_start_i  (ramp_a_start_i),
    .ramp_b_start_i  (ramp_b_start_i),
    .up_start_i      (up_start_i),
    .capture_valid_i (capture_valid_i),
    .cap_mode_i      (cap_mode_i),
    .circ_en_i       (circ_en_i),
    .cap_read_i      (cap_read_i),
    .ovf_ack_i       (ovf_ack_i),
    .ovf_req_o       (ovf_req_o),
    .ch_req_o        (ch_req_o)
);

// File: tb/pwm_dma_reqgen_tb_top.sv
module pwm_dma_reqgen_tb_top;
    import pwm_dma_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH       = 4;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [MODE_W-1:0] wave_mode = WM_SINGLE;
    logic              oneshot_en = 1'b0, oneshot_cmd = 1'b0;
    logic              ovf_evt = 1'b0, unf_evt = 1'b0, retrig_evt = 1'b0;
    logic              ramp_a = 1'b0, ramp_b = 1'b0, up_st = 1'b0, down_st = 1'b0;
    logic [N_CH-1:0]   match = '0, cap_valid = '0, cap_mode = '0, circ_en = '0, cap_read = '0;
    logic              ovf_ack = 1'b0;
    logic [N_CH-1:0]   ch_ack = '0;
    logic              ovf_req;
    logic [N_CH-1:0]   ch_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dma_reqgen #(.N_CH(N_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wave_mode_i(wave_mode),
        .oneshot_en_i(oneshot_en), .oneshot_cmd_i(oneshot_cmd),
        .ovf_evt_i(ovf_evt), .unf_evt_i(unf_evt), .retrig_evt_i(retrig_evt),
        .ramp_a_start_i(ramp_a), .ramp_b_start_i(ramp_b),
        .up_start_i(up_st), .down_start_i(down_st),
        .match_i(match), .capture_valid_i(cap_valid), .cap_mode_i(cap_mode),
        .circ_en_i(circ_en), .cap_read_i(cap_read),
        .ovf_ack_i(ovf_ack), .ch_ack_i(ch_ack),
        .ovf_req_o(ovf_req), .ch_req_o(ch_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        oneshot_cmd = 0; ovf_evt = 0; unf_evt = 0; retrig_evt = 0;
        ramp_a = 0; ramp_b = 0; up_st = 0; down_st = 0;
        match = '0; cap_valid = '0; cap_read = '0; ovf_ack = 0; ch_ack = '0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        ovf_evt = 1; match = '1;
        repeat (3) cyc();
        chk("R1 in reset ovf", {31'd0, ovf_req}, 0);
        clear_strobes();
        rst_n = 1;
        cyc();
        chk("R1 after reset ovf", {31'd0, ovf_req}, 0);
        chk("R1 after reset ch", {28'd0, ch_req}, 0);
    endtask

    task automatic t_update_direct();
        wave_mode = WM_SINGLE; oneshot_en = 0;
        ovf_evt = 1; cyc(); clear_strobes();
        chk("R2 overflow", {31'd0, ovf_req}, 1);
        ovf_ack = 1; cyc(); clear_strobes();
        chk("R5 ack clears", {31'd0, ovf_req}, 0);
        unf_evt = 1; cyc(); clear_strobes();
        chk("R2 underflow", {31'd0, ovf_req}, 1);
        ovf_ack = 1; cyc(); clear_strobes();
        retrig_evt = 1; cyc(); clear_strobes();
        chk("R2 retrigger", {31'd0, ovf_req}, 1);
        retrig_evt = 1; ovf_ack = 1; cyc(); clear_strobes();
        chk("R5 set wins over ack", {31'd0, ovf_req}, 1);
        ovf_ack = 1; cyc(); clear_strobes();
        chk("R5 ack after collision", {31'd0, ovf_req}, 0);
    endtask

    task automatic t_oneshot();
        oneshot_en = 1;
        ovf_evt = 1; cyc(); clear_strobes();
        chk("R3 no direct request", {31'd0, ovf_req}, 0);
        cyc();
        chk("R3 still held", {31'd0, ovf_req}, 0);
        oneshot_cmd = 1; cyc(); clear_strobes();
        chk("R3 command fires", {31'd0, ovf_req}, 1);
        ovf_ack = 1; cyc(); clear_strobes();
        chk("R3 ack after command", {31'd0, ovf_req}, 0);
        oneshot_cmd = 1; cyc(); clear_strobes();
        chk("R3 command consumed event", {31'd0, ovf_req}, 0);
    endtask

    task automatic t_oneshot_drop();
        oneshot_en = 1;
        unf_evt = 1; cyc(); clear_strobes();
        oneshot_en = 0; cyc();
        chk("R4 disable raises nothing", {31'd0, ovf_req}, 0);
        oneshot_en = 1;
        oneshot_cmd = 1; cyc(); clear_strobes();
        chk("R4 event discarded", {31'd0, ovf_req}, 0);
        oneshot_en = 0;
    endtask

    task automatic t_match();
        match = 4'b0001; cyc(); clear_strobes();
        chk("R6 match ch0", {28'd0, ch_req}, 32'h1);
        match = 4'b0100; cyc(); clear_strobes();
        chk("R6 match ch2", {28'd0, ch_req}, 32'h5);
        ch_ack = 4'b0001; cyc(); clear_strobes();
        chk("R6 ack ch0", {28'd0, ch_req}, 32'h4);
        match = 4'b0100; ch_ack = 4'b0100; cyc(); clear_strobes();
        chk("R6 match wins over ack", {28'd0, ch_req}, 32'h4);
        ch_ack = 4'b0100; cyc(); clear_strobes();
        chk("R6 ack ch2", {28'd0, ch_req}, 32'h0);
    endtask

    task automatic t_match_oneshot();
        oneshot_en = 1;
        match = '1; cyc(); clear_strobes();
        chk("R7 matches blocked", {28'd0, ch_req}, 32'h0);
        oneshot_en = 0;
    endtask

    task automatic t_capture();
        cap_mode = 4'b0010; oneshot_en = 1;
        cap_valid = 4'b0010; cyc(); clear_strobes();
        chk("R8 capture sets in one-shot", {28'd0, ch_req}, 32'h2);
        ch_ack = 4'b0010; cyc(); clear_strobes();
        chk("R8 ack ignored", {28'd0, ch_req}, 32'h2);
        cap_read = 4'b0010; cyc(); clear_strobes();
        chk("R8 read clears", {28'd0, ch_req}, 32'h0);
        oneshot_en = 0; cap_mode = '0;
    endtask

    task automatic t_tworamp();
        wave_mode = WM_TWORAMP; circ_en = 4'b0001;
        match = 4'b0011; cyc(); clear_strobes();
        chk("R9 circ ignores match", {28'd0, ch_req}, 32'h2);
        ch_ack = 4'b0010; cyc(); clear_strobes();
        ramp_b = 1; cyc(); clear_strobes();
        chk("R9 ramp B start", {28'd0, ch_req}, 32'h1);
        ch_ack = 4'b0001; cyc(); clear_strobes();
        ovf_evt = 1; cyc(); clear_strobes();
        chk("R10 update ignored", {31'd0, ovf_req}, 0);
        ramp_a = 1; cyc(); clear_strobes();
        chk("R10 no ack in ramp B", {31'd0, ovf_req}, 0);
        ramp_b = 1; cyc(); clear_strobes();
        ch_ack = 4'b0001; ovf_ack = 1; cyc(); clear_strobes();
        ramp_a = 1; cyc(); clear_strobes();
        chk("R10 acked ramp B", {31'd0, ovf_req}, 1);
        ovf_ack = 1; cyc(); clear_strobes();
        ramp_b = 1; cyc(); clear_strobes();
        ramp_a = 1; cyc(); clear_strobes();
        chk("R10 stale ack not counted", {31'd0, ovf_req}, 0);
        ch_ack = 4'b0001; cyc(); clear_strobes();
        wave_mode = WM_TWORAMP_ALT;
        ramp_b = 1; cyc(); clear_strobes();
        chk("R9 alternate ramp B start", {28'd0, ch_req}, 32'h1);
        ch_ack = 4'b0001; cyc(); clear_strobes();
    endtask

    task automatic t_dual();
        wave_mode = WM_DUAL_BOTH; circ_en = 4'b0001;
        ramp_b = 1; cyc(); clear_strobes();
        chk("R11 ramp B inert", {28'd0, ch_req}, 32'h0);
        down_st = 1; cyc(); clear_strobes();
        chk("R11 down start", {28'd0, ch_req}, 32'h1);
        up_st = 1; cyc(); clear_strobes();
        chk("R11 no ack in down", {31'd0, ovf_req}, 0);
        down_st = 1; cyc(); clear_strobes();
        ovf_ack = 1; ch_ack = 4'b0001; cyc(); clear_strobes();
        ramp_a = 1; cyc(); clear_strobes();
        chk("R11 ramp A inert", {31'd0, ovf_req}, 0);
        up_st = 1; cyc(); clear_strobes();
        chk("R11 up start after ack", {31'd0, ovf_req}, 1);
        ovf_ack = 1; cyc(); clear_strobes();
    endtask

    task automatic t_fallback();
        wave_mode = WM_SINGLE; circ_en = 4'b0001;
        match = 4'b0001; cyc(); clear_strobes();
        chk("R12 single-slope match", {28'd0, ch_req}, 32'h1);
        ch_ack = 4'b0001; cyc(); clear_strobes();
        ovf_evt = 1; cyc(); clear_strobes();
        chk("R12 update drives overflow", {31'd0, ovf_req}, 1);
        ovf_ack = 1; cyc(); clear_strobes();
        wave_mode = WM_DUAL_TOP;
        down_st = 1; ramp_b = 1; cyc(); clear_strobes();
        chk("R12 dual-top phase inert", {28'd0, ch_req}, 32'h0);
        match = 4'b0001; cyc(); clear_strobes();
        chk("R12 dual-top match", {28'd0, ch_req}, 32'h1);
        ch_ack = 4'b0001; cyc(); clear_strobes();
        circ_en = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        cyc();
        t_reset();
        t_update_direct();
        t_oneshot();
        t_oneshot_drop();
        t_match();
        t_match_oneshot();
        t_capture();
        t_tworamp();
        t_dual();
        t_fallback();
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule